// File: doc/BRIEF.md
# Horizontal Line Divider with Selectable Line Length

This block is the feedback divider of a line-locked pixel clock generator. It counts cycles of the output pixel clock and wraps once per video line. At each wrap it raises a one-cycle line pulse, which goes back to the phase comparator. The number of pixel clocks per line comes from a 3-bit mode code. The top bit picks the video standard (1 = 525-line NTSC family, 0 = 625-line PAL family). The two low bits pick one of four sampling schemes within that standard.

One PAL sampling scheme needs 567.5 clocks per line. The block meets this on average by alternating lines of 567 and 568 clocks. The block also drives a clock at half the input rate, and it brings out the running pixel position so that downstream timing can decode it.

The mode code is read only in the first cycle of each line, which is the cycle in which the pixel count is zero. A line that is already running always keeps the length it started with.

Top module: `hline_divider`

## Requirements
- R1: While reset is asserted, pix_cnt is 0, line_pulse is 0 and half_clk is 0.
- R2: After reset is released, half_clk inverts on every rising clock edge, so the first edge drives it to 1.
- R3: pix_cnt starts at 0 after reset and rises by one on each clock. After reaching line length minus one it returns to 0, and it never reaches the largest line length in the table.
- R4: line_pulse is high for exactly one cycle, the cycle in which pix_cnt has just wrapped to 0. It is low in the cycles that follow reset.
- R5: NTSC codes (bit 2 = 1) give these line lengths: code 3'b100 gives 858, 3'b101 gives 800, 3'b110 gives 455 and 3'b111 gives 390.
- R6: PAL codes (bit 2 = 0) give these line lengths: code 3'b000 gives 864, 3'b010 gives 480 and 3'b011 gives 472.
- R7: Code 3'b001 (567.5 per line) gives line lengths that alternate 567, 568, 567, 568 and so on. The first such line after reset has 567 clocks.
- R8: mode is sampled only on the edge that ends a cycle with pix_cnt equal to 0. A change of mode at any other time does not alter the length of the line in progress, and it applies from the next line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock from the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | {standard bit, two-bit scheme select}; sampled at line start |
| line_pulse | output | 1 | One-cycle pulse on each line wrap |
| half_clk | output | 1 | Input clock divided by two |
| pix_cnt | output | CNT_W (10) | Pixel position within the current line |

## Verification
The assertions assume that reset is held for at least one rising edge. They also assume that every table entry is far longer than one cycle, so a wrap can never happen in the same cycle as the mode sample. The stimulus changes mode and reset only on falling edges, so each value is stable at the sampling edge. The bench changes mode either exactly in the wrap cycle or deep inside a line, which exercises both the sampling point and the hold-off. The half-line mode is entered straight out of reset, so the alternation starts from a known phase.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
   localparam int MODE_W    = 3;
   localparam int NUM_MODES = 1 << MODE_W;

   typedef struct packed {
      logic       ntsc;
      logic [1:0] scheme;
   } vmode_t;

   function automatic logic [MODE_W-1:0] mode_index(input vmode_t m);
      return {m.ntsc, m.scheme};
   endfunction
endpackage

// File: rtl/hdiv_mode_table.sv
module hdiv_mode_table
   import hdiv_pkg::*;
#(
   parameter int                           LEN_W     = 12,
   parameter int                           CNT_W     = 10,
   parameter logic [NUM_MODES*LEN_W-1:0]   LEN_TABLE = '0,
   parameter logic [MODE_W-1:0]            HALF_CODE = 3'b001
) (
   input  logic [MODE_W-1:0] code,
   output logic [CNT_W-1:0]  last_base,
   output logic              is_half
);
   logic [CNT_W-1:0] last_of [NUM_MODES];

   for (genvar i = 0; i < NUM_MODES; i++) begin : g_entry
      localparam logic [LEN_W-1:0] ENT_LEN  = LEN_TABLE[i*LEN_W +: LEN_W];
      localparam logic [LEN_W-1:0] ENT_LAST = ENT_LEN - LEN_W'(1);
      if (ENT_LEN < 2) begin : g_too_short
         $error("hdiv_mode_table: entry %0d shorter than two cycles", i);
      end
      if (int'(ENT_LEN) >= (1 << CNT_W) - 1) begin : g_too_long
         $error("hdiv_mode_table: entry %0d does not fit the counter", i);
      end
      assign last_of[i] = CNT_W'(ENT_LAST);
   end

   always_comb begin
      last_base = last_of[code];
      is_half   = (code == HALF_CODE);
   end
endmodule

// File: rtl/hdiv_line_ctr.sv
module hdiv_line_ctr
   import hdiv_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_in,
   input  logic [CNT_W-1:0]  last_base,
   input  logic              is_half,
   output logic [MODE_W-1:0] act_code,
   output logic [CNT_W-1:0]  pix_cnt,
   output logic              line_pulse
);
   logic             long_phase;
   logic [CNT_W-1:0] last_val;
   logic             at_end;

   always_comb begin
      last_val = last_base + CNT_W'(is_half & long_phase);
      at_end   = (pix_cnt == last_val);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_cnt    <= '0;
         line_pulse <= 1'b0;
         long_phase <= 1'b0;
         act_code   <= '0;
      end else begin
         if (pix_cnt == '0) begin
            act_code <= mode_in;
         end
         if (at_end) begin
            pix_cnt    <= '0;
            line_pulse <= 1'b1;
            if (is_half) begin
               long_phase <= ~long_phase;
            end
         end else begin
            pix_cnt    <= pix_cnt + CNT_W'(1);
            line_pulse <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hdiv_half_clk.sv
module hdiv_half_clk (
   input  logic clk,
   input  logic rst_n,
   output logic half_clk
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_clk <= 1'b0;
      end else begin
         half_clk <= ~half_clk;
      end
   end
endmodule

// File: rtl/hline_divider.sv
module hline_divider
   import hdiv_pkg::*;
#(
   parameter int                          CNT_W     = 10,
   parameter int                          LEN_W     = 12,
   parameter logic [NUM_MODES*LEN_W-1:0]  LEN_TABLE = {12'd390, 12'd455, 12'd800, 12'd858,
                                                       12'd472, 12'd480, 12'd567, 12'd864},
   parameter logic [MODE_W-1:0]           HALF_CODE = 3'b001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode,
   output logic             line_pulse,
   output logic             half_clk,
   output logic [CNT_W-1:0] pix_cnt
);
   function automatic int table_max(input logic [NUM_MODES*LEN_W-1:0] t);
      int m = 0;
      for (int i = 0; i < NUM_MODES; i++) begin
         if (int'(t[i*LEN_W +: LEN_W]) > m) m = int'(t[i*LEN_W +: LEN_W]);
      end
      return m;
   endfunction

   localparam int MAX_LEN = table_max(LEN_TABLE) + 1;

   if (LEN_W < CNT_W) begin : g_bad_width
      $error("hline_divider: LEN_W must be at least CNT_W");
   end
   if (MODE_W != 3) begin : g_bad_mode
      $error("hline_divider: mode port assumes a 3-bit code");
   end

   vmode_t            mode_s;
   logic [MODE_W-1:0] act_code;
   logic [CNT_W-1:0]  last_base;
   logic              is_half;

   assign mode_s = vmode_t'(mode);

   hdiv_mode_table #(
      .LEN_W     (LEN_W),
      .CNT_W     (CNT_W),
      .LEN_TABLE (LEN_TABLE),
      .HALF_CODE (HALF_CODE)
   ) u_table (
      .code      (act_code),
      .last_base (last_base),
      .is_half   (is_half)
   );

   hdiv_line_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_in    (mode_index(mode_s)),
      .last_base  (last_base),
      .is_half    (is_half),
      .act_code   (act_code),
      .pix_cnt    (pix_cnt),
      .line_pulse (line_pulse)
   );

   hdiv_half_clk u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_clk (half_clk)
   );
endmodule

// File: rtl/hline_divider_chk.sv
module hline_divider_chk #(
   parameter int CNT_W   = 10,
   parameter int MAX_LEN = 865
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] pix_cnt,
   input logic             line_pulse,
   input logic             half_clk,
   input logic [2:0]       act_code
);
   // R2
   half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> half_clk != $past(half_clk));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_cnt != '0) |=> (pix_cnt == '0) || (pix_cnt == $past(pix_cnt) + CNT_W'(1)));

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pix_cnt) < MAX_LEN - 1);

   // R4
   pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_pulse |-> (pix_cnt == '0));

   // R4
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_pulse |=> !line_pulse);

   // R4
   wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pix_cnt == '0) && ($past(pix_cnt) != '0)) |-> line_pulse);

   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_cnt != '0) |=> $stable(act_code));
endmodule

bind hline_divider hline_divider_chk #(
   .CNT_W   (CNT_W),
   .MAX_LEN (MAX_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_cnt    (pix_cnt),
   .line_pulse (line_pulse),
   .half_clk   (half_clk),
   .act_code   (act_code)
);

// File: tb/tb_hline_divider.sv
module tb_hline_divider;
   localparam int CLK_PERIOD = 10;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode  = 3'b100;
   logic       line_pulse;
   logic       half_clk;
   logic [9:0] pix_cnt;

   int  checks = 0;
   int  errors = 0;
   bit  cmp_en = 1'b0;

   hline_divider dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .line_pulse (line_pulse),
      .half_clk   (half_clk),
      .pix_cnt    (pix_cnt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int nominal(input logic [2:0] code);
      case (code)
         3'b000:  return 864;
         3'b001:  return 567;
         3'b010:  return 480;
         3'b011:  return 472;
         3'b100:  return 858;
         3'b101:  return 800;
         3'b110:  return 455;
         default: return 390;
      endcase
   endfunction

   // Behavioural reference: position within line, line length chosen at line start
   int m_pos = 0, m_len = 0, m_alt = 0;
   bit m_half = 0, m_pulse = 0, m_hclk = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_len = 0; m_alt = 0; m_pulse = 0; m_hclk = 0; m_half = 0;
      end else begin
         m_hclk = ~m_hclk;
         if (m_pos == 0) begin
            m_half = (mode == 3'b001);
            m_len  = nominal(mode) + (m_half ? m_alt : 0);
         end
         if (m_pos == m_len - 1) begin
            m_pos   = 0;
            m_pulse = 1;
            if (m_half) m_alt ^= 1;
         end else begin
            m_pos++;
            m_pulse = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         check(int'(pix_cnt) == m_pos, "R3 pix_cnt", int'(pix_cnt), m_pos);
         check(line_pulse == m_pulse, "R4 line_pulse", int'(line_pulse), int'(m_pulse));
         check(half_clk == m_hclk, "R2 half_clk", int'(half_clk), int'(m_hclk));
      end
   end

   task automatic wait_pulse();
      while (!line_pulse) @(negedge clk);
   endtask

   task automatic count_line(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!line_pulse);
   endtask

   task automatic run_line(input logic [2:0] code, input string tag);
      int n;
      wait_pulse();
      mode = code;
      count_line(n);
      check(n == nominal(code), tag, n, nominal(code));
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int n;
      mode  = 3'b100;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(pix_cnt == '0, "R1 pix_cnt in reset", int'(pix_cnt), 0);
      check(line_pulse == 1'b0, "R1 line_pulse in reset", int'(line_pulse), 0);
      check(half_clk == 1'b0, "R1 half_clk in reset", int'(half_clk), 0);
      rst_n  = 1'b1;
      cmp_en = 1'b1;
      count_line(n);
      check(n == 858, "R5 first line after reset", n, 858);

      // R5 NTSC lengths
      for (int k = 4; k < 8; k++) begin
         run_line(3'(k), "R5 NTSC line length");
         run_line(3'(k), "R5 NTSC line length repeat");
      end
      // R6 PAL integer lengths
      run_line(3'b000, "R6 PAL line length");
      run_line(3'b000, "R6 PAL line length repeat");
      for (int k = 2; k < 4; k++) begin
         run_line(3'(k), "R6 PAL line length");
         run_line(3'(k), "R6 PAL line length repeat");
      end

      // R8 change in mid-line keeps current length
      run_line(3'b100, "R8 set long mode");
      repeat (100) @(negedge clk);
      mode = 3'b111;
      count_line(n);
      check(n == 858 - 100, "R8 mid-line change ignored", n + 100, 858);
      count_line(n);
      check(n == 390, "R8 new mode on next line", n, 390);

      // R7 half-line alternation from reset
      cmp_en = 1'b0;
      rst_n  = 1'b0;
      mode   = 3'b001;
      repeat (2) @(negedge clk);
      rst_n  = 1'b1;
      cmp_en = 1'b1;
      count_line(n);
      check(n == 567, "R7 first half-mode line", n, 567);
      count_line(n);
      check(n == 568, "R7 second half-mode line", n, 568);
      count_line(n);
      check(n == 567, "R7 third half-mode line", n, 567);
      count_line(n);
      check(n == 568, "R7 fourth half-mode line", n, 568);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule